// File: doc/BRIEF.md
# SPI Pin-Direction and Mode-Fault Supervisor

This block sits between the control bits of an SPI master/slave core and its pads. From the enable, master-select, single-wire (bidirectional) mode, single-wire output-enable, slave-select-output and fault-detect-enable bits, it works out which pads the core drives. The pads are the two data pads (called MOSI and MISO here), the clock pad and the select pad. It also chooses which data pad feeds the shift register's serial input.

The block also watches the slave-select pad for a multi-master conflict. When the core is master and fault detection is on, a low select level means another master is driving the bus. The block then raises a sticky fault flag, releases every pad, aborts any running transfer and discards a byte in flight. It also sends clear pulses to the register file so that the master-select bit drops and, in single-wire mode, the data output-enable bit drops too. The flag clears only when a status read with the flag set is followed later by a write to control register 1.

The shift register, baud generator and register file are outside the block. Their part is played by the busy, byte-done, status-read and control-write inputs and by the clear-pulse outputs.

Top module: `spi_pinctl`

## Requirements
- R1: With enable=1, master=1, single-wire=0 and no fault: mosi_oe=1, miso_oe=0, sck_oe=1, and sin_sel=1 (1 selects the MISO pad, 0 selects the MOSI pad).
- R2: With enable=1, master=0, single-wire=0: mosi_oe=0, miso_oe=1, sck_oe=0, ss_oe=0, sin_sel=0.
- R3: With enable=1, master=1, single-wire=1 and no fault: mosi_oe equals the single-wire output-enable bit, miso_oe=0, sck_oe=1, sin_sel=0.
- R4: With enable=1, master=0, single-wire=1: miso_oe equals the single-wire output-enable bit, mosi_oe=0, sck_oe=0, sin_sel=1.
- R5: With enable=0, all four output enables are 0. In every state, sin_sel equals (master and not fault) XOR single-wire.
- R6: As master with enable=1 and fault detection=1, a select pad held low sets modf_o on the third rising edge after the change, because of a two-flop synchronizer.
- R7: As master with fault detection=0, the select pad has no effect and modf_o stays 0. ss_oe=1 exactly when the core is an active master, slave-select-output=1 and fault detection=0.
- R8: As slave, a low select pad never sets modf_o.
- R9: While modf_o=1, every output enable is 0 and master_o is 0. On the edge that sets modf_o, clr_mstr_o pulses for one cycle, and abort_o pulses for one cycle if busy_i was 1.
- R10: A fault taken in single-wire mode with the output-enable bit set pulses clr_bidir_oe_o in the same cycle as clr_mstr_o. A fault taken in normal mode does not pulse it.
- R11: rx_full_set_o follows rx_done_i, except that it is 0 in the cycle where a fault is detected and for as long as modf_o=1.
- R12: modf_o clears on the edge of a ctrl1_wr_i that was preceded, in an earlier cycle with modf_o=1, by stat_rd_i. A control write with no such read leaves modf_o set and consumes nothing.
- R13: While modf_o=1, further select-pad activity produces no new abort_o or clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spe_i | input | 1 | Core enable |
| mstr_i | input | 1 | Master-select control bit |
| bidir_i | input | 1 | Single-wire data mode |
| bidir_oe_i | input | 1 | Single-wire data pad output enable |
| ss_out_i | input | 1 | Master drives the select pad when fault detection is off |
| modf_en_i | input | 1 | Mode-fault detection enable |
| ss_n_i | input | 1 | Raw select pad level, active low |
| busy_i | input | 1 | Transfer in progress, from the shifter |
| rx_done_i | input | 1 | Shifter completed a received byte |
| stat_rd_i | input | 1 | Status register read strobe |
| ctrl1_wr_i | input | 1 | Control register 1 write strobe |
| mosi_oe_o | output | 1 | MOSI pad output enable |
| miso_oe_o | output | 1 | MISO pad output enable |
| sck_oe_o | output | 1 | Clock pad output enable |
| ss_oe_o | output | 1 | Select pad output enable |
| sin_sel_o | output | 1 | Serial input source: 0 MOSI pad, 1 MISO pad |
| master_o | output | 1 | Core is currently acting as an enabled master |
| modf_o | output | 1 | Mode-fault flag |
| abort_o | output | 1 | One-cycle transfer abort pulse |
| clr_mstr_o | output | 1 | One-cycle pulse clearing the master-select bit |
| clr_bidir_oe_o | output | 1 | One-cycle pulse clearing the single-wire output enable |
| rx_full_set_o | output | 1 | Receive-full set request, gated by fault |

## Verification
If the fault flag or the clear-sequence state is wrong, the pads show it on the very next cycle. A stuck or missing flag leaves a pad driven when it should float, or releases the pads while the core is still a healthy master. A lost or stale armed state from the status read shows on the clock edge of the next control write: the flag either fails to clear or clears without a read. A synchronizer of the wrong depth moves the rising edge of the flag and of the abort pulse off the third cycle after the select change, so the bench checks that exact cycle.

// File: rtl/spi_pinctl_pkg.sv
package spi_pinctl_pkg;

    // serial input source encoding
    typedef enum logic {
        SIN_MOSI = 1'b0,
        SIN_MISO = 1'b1
    } sin_src_e;

    // registered state of the fault supervisor
    typedef struct packed {
        logic modf;
        logic armed;
        logic abort;
        logic clr_mstr;
        logic clr_oe;
    } flt_state_t;

endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/spi_fault_ctl.sv
module spi_fault_ctl
    import spi_pinctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic spe,
    input  logic mstr,
    input  logic bidir,
    input  logic bidir_oe,
    input  logic modf_en,
    input  logic ss_lvl,
    input  logic busy,
    input  logic stat_rd,
    input  logic ctrl_wr,
    output logic fault_now,
    output flt_state_t st
);
    flt_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.abort    = 1'b0;
        st_d.clr_mstr = 1'b0;
        st_d.clr_oe   = 1'b0;
        fault_now     = spe & mstr & modf_en & ~ss_lvl & ~st_q.modf;
        if (st_q.modf) begin
            if (ctrl_wr) begin
                if (st_q.armed) st_d.modf = 1'b0;
                st_d.armed = 1'b0;
            end else if (stat_rd) begin
                st_d.armed = 1'b1;
            end
        end else if (fault_now) begin
            st_d.modf     = 1'b1;
            st_d.armed    = 1'b0;
            st_d.abort    = busy;
            st_d.clr_mstr = 1'b1;
            st_d.clr_oe   = bidir & bidir_oe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/spi_pad_dir.sv
module spi_pad_dir
    import spi_pinctl_pkg::*;
(
    input  logic     spe,
    input  logic     mstr_act,
    input  logic     modf,
    input  logic     bidir,
    input  logic     bidir_oe,
    input  logic     ss_out,
    input  logic     modf_en,
    output logic     mosi_oe,
    output logic     miso_oe,
    output logic     sck_oe,
    output logic     ss_oe,
    output sin_src_e sin_sel
);
    logic live;

    always_comb begin
        live    = spe & ~modf;
        mosi_oe = 1'b0;
        miso_oe = 1'b0;
        if (live) begin
            if (mstr_act) mosi_oe = bidir ? bidir_oe : 1'b1;
            else          miso_oe = bidir ? bidir_oe : 1'b1;
        end
        sck_oe  = live & mstr_act;
        ss_oe   = live & mstr_act & ss_out & ~modf_en;
        sin_sel = (mstr_act ^ bidir) ? SIN_MISO : SIN_MOSI;
    end
endmodule

// File: rtl/spi_pinctl.sv
module spi_pinctl
    import spi_pinctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spe_i,
    input  logic mstr_i,
    input  logic bidir_i,
    input  logic bidir_oe_i,
    input  logic ss_out_i,
    input  logic modf_en_i,
    input  logic ss_n_i,
    input  logic busy_i,
    input  logic rx_done_i,
    input  logic stat_rd_i,
    input  logic ctrl1_wr_i,
    output logic mosi_oe_o,
    output logic miso_oe_o,
    output logic sck_oe_o,
    output logic ss_oe_o,
    output logic sin_sel_o,
    output logic master_o,
    output logic modf_o,
    output logic abort_o,
    output logic clr_mstr_o,
    output logic clr_bidir_oe_o,
    output logic rx_full_set_o
);
    logic       ss_lvl;
    logic       fault_now;
    logic       mstr_act;
    flt_state_t st;
    sin_src_e   sin_src;

    spi_ss_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ss_n_i),
        .dout (ss_lvl)
    );

    spi_fault_ctl i_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .spe      (spe_i),
        .mstr     (mstr_i),
        .bidir    (bidir_i),
        .bidir_oe (bidir_oe_i),
        .modf_en  (modf_en_i),
        .ss_lvl   (ss_lvl),
        .busy     (busy_i),
        .stat_rd  (stat_rd_i),
        .ctrl_wr  (ctrl1_wr_i),
        .fault_now(fault_now),
        .st       (st)
    );

    assign mstr_act = mstr_i & ~st.modf;

    spi_pad_dir i_pads (
        .spe     (spe_i),
        .mstr_act(mstr_act),
        .modf    (st.modf),
        .bidir   (bidir_i),
        .bidir_oe(bidir_oe_i),
        .ss_out  (ss_out_i),
        .modf_en (modf_en_i),
        .mosi_oe (mosi_oe_o),
        .miso_oe (miso_oe_o),
        .sck_oe  (sck_oe_o),
        .ss_oe   (ss_oe_o),
        .sin_sel (sin_src)
    );

    assign sin_sel_o      = sin_src;
    assign master_o       = spe_i & mstr_act;
    assign modf_o         = st.modf;
    assign abort_o        = st.abort;
    assign clr_mstr_o     = st.clr_mstr;
    assign clr_bidir_oe_o = st.clr_oe;
    assign rx_full_set_o  = rx_done_i & ~st.modf & ~fault_now;
endmodule

// File: rtl/spi_pinctl_chk.sv
module spi_pinctl_chk (
    input logic clk,
    input logic rst_n,
    input logic spe_i,
    input logic mstr_i,
    input logic modf_en_i,
    input logic busy_i,
    input logic ctrl1_wr_i,
    input logic mosi_oe_o,
    input logic miso_oe_o,
    input logic sck_oe_o,
    input logic ss_oe_o,
    input logic master_o,
    input logic modf_o,
    input logic abort_o,
    input logic clr_mstr_o,
    input logic clr_bidir_oe_o,
    input logic rx_full_set_o
);
    p_fault_pads_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        modf_o |-> !(mosi_oe_o || miso_oe_o || sck_oe_o || ss_oe_o || master_o));

    p_fault_needs_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf_o) |-> $past(spe_i && mstr_i && modf_en_i));

    p_clear_on_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(modf_o) |-> $past(ctrl1_wr_i));

    p_pulses_on_entry_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o || clr_mstr_o || clr_bidir_oe_o) |-> $rose(modf_o));

    p_abort_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf_o) |-> (abort_o == $past(busy_i)) && clr_mstr_o);

    p_rx_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        modf_o |-> !rx_full_set_o);

    p_one_data_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe_o && miso_oe_o));

    p_slave_no_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master_o |-> !sck_oe_o);
endmodule

bind spi_pinctl spi_pinctl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .spe_i         (spe_i),
    .mstr_i        (mstr_i),
    .modf_en_i     (modf_en_i),
    .busy_i        (busy_i),
    .ctrl1_wr_i    (ctrl1_wr_i),
    .mosi_oe_o     (mosi_oe_o),
    .miso_oe_o     (miso_oe_o),
    .sck_oe_o      (sck_oe_o),
    .ss_oe_o       (ss_oe_o),
    .master_o      (master_o),
    .modf_o        (modf_o),
    .abort_o       (abort_o),
    .clr_mstr_o    (clr_mstr_o),
    .clr_bidir_oe_o(clr_bidir_oe_o),
    .rx_full_set_o (rx_full_set_o)
);

// File: tb/test_spi_pinctl.sv
`timescale 1ns/100ps
module test_spi_pinctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spe_i = 0, mstr_i = 0, bidir_i = 0, bidir_oe_i = 0, ss_out_i = 0, modf_en_i = 0;
    logic ss_n_i = 1, busy_i = 0, rx_done_i = 0, stat_rd_i = 0, ctrl1_wr_i = 0;
    logic mosi_oe_o, miso_oe_o, sck_oe_o, ss_oe_o, sin_sel_o, master_o, modf_o;
    logic abort_o, clr_mstr_o, clr_bidir_oe_o, rx_full_set_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_pinctl i_spi_pinctl (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // {mosi_oe, miso_oe, sck_oe, ss_oe, sin_sel}
    function automatic logic [4:0] exp_pads(input logic spe, mstr, bidir, oe, ssout, mfen, modf);
        logic m, on, mo, mi;
        m  = mstr & ~modf;
        on = spe & ~modf;
        mo = on & m  & (bidir ? oe : 1'b1);
        mi = on & ~m & (bidir ? oe : 1'b1);
        return {mo, mi, on & m, on & m & ssout & ~mfen, m ^ bidir};
    endfunction

    function automatic string mode_req(input logic spe, mstr, bidir);
        if (!spe) return "R5";
        if (mstr) return bidir ? "R3" : "R1";
        return bidir ? "R4" : "R2";
    endfunction

    function automatic logic [4:0] pads();
        return {mosi_oe_o, miso_oe_o, sck_oe_o, ss_oe_o, sin_sel_o};
    endfunction

    task automatic set_mode(input logic spe, mstr, bidir, oe, ssout, mfen);
        spe_i = spe; mstr_i = mstr; bidir_i = bidir; bidir_oe_i = oe;
        ss_out_i = ssout; modf_en_i = mfen;
    endtask

    task automatic clear_flag();
        ss_n_i = 1'b1; tick(3);
        stat_rd_i = 1'b1; tick(1); stat_rd_i = 1'b0;
        ctrl1_wr_i = 1'b1; tick(1); ctrl1_wr_i = 1'b0;
    endtask

    initial begin
        #20000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R5 reset pads", pads(), 5'b00000);
        check("R9 reset modf", modf_o, 0);

        // random mode sweep, no fault possible (select pad high)
        for (int k = 0; k < 200; k++) begin
            logic s, m, b, o, so, fe, rd;
            s = $urandom; m = $urandom; b = $urandom; o = $urandom;
            so = $urandom; fe = $urandom; rd = $urandom;
            set_mode(s, m, b, o, so, fe);
            rx_done_i = rd;
            busy_i = $urandom;
            tick(1);
            check(mode_req(s, m, b), pads(), exp_pads(s, m, b, o, so, fe, 0));
            check("R7 master_o", master_o, s & m);
            check("R11 rx pass", rx_full_set_o, rd);
        end
        rx_done_i = 0; busy_i = 0;

        // R7: fault detection off, low select ignored, select driven
        set_mode(1, 1, 0, 0, 1, 0);
        ss_n_i = 1'b0; tick(5);
        check("R7 no modf", modf_o, 0);
        check("R7 pads", pads(), exp_pads(1, 1, 0, 0, 1, 0, 0));
        ss_n_i = 1'b1; tick(3);

        // R8: slave, detection on, low select ignored
        set_mode(1, 0, 0, 0, 0, 1);
        ss_n_i = 1'b0; tick(5);
        check("R8 slave no modf", modf_o, 0);
        check("R8 slave pads", pads(), exp_pads(1, 0, 0, 0, 0, 1, 0));
        ss_n_i = 1'b1; tick(3);

        // R6/R9/R11: fault during transfer, normal master
        set_mode(1, 1, 0, 0, 0, 1);
        busy_i = 1'b1; rx_done_i = 1'b0;
        ss_n_i = 1'b0; tick(2);
        check("R6 not yet", modf_o, 0);
        rx_done_i = 1'b1;
        #0.1;
        check("R11 detect cycle", rx_full_set_o, 0);
        tick(1);
        check("R6 modf set", modf_o, 1);
        check("R9 abort", abort_o, 1);
        check("R9 clr_mstr", clr_mstr_o, 1);
        check("R10 normal no clr_oe", clr_bidir_oe_o, 0);
        check("R9 pads off", pads(), exp_pads(1, 1, 0, 0, 0, 1, 1));
        check("R9 master_o", master_o, 0);
        check("R11 rx blocked", rx_full_set_o, 0);
        tick(1);
        check("R9 abort one cycle", abort_o, 0);
        check("R9 clr one cycle", clr_mstr_o, 0);
        rx_done_i = 1'b0; busy_i = 1'b0;

        // R13: more select activity while faulted
        for (int k = 0; k < 4; k++) begin
            ss_n_i = ~ss_n_i; busy_i = 1'b1; tick(3);
            check("R13 no new abort", abort_o, 0);
            check("R13 no new clr", clr_mstr_o, 0);
        end
        busy_i = 1'b0;

        // R12: write with no read keeps the flag
        ss_n_i = 1'b1; tick(3);
        ctrl1_wr_i = 1'b1; tick(1); ctrl1_wr_i = 1'b0;
        check("R12 write alone", modf_o, 1);
        tick(1);
        // read and write in the same cycle is not a sequence
        stat_rd_i = 1'b1; ctrl1_wr_i = 1'b1; tick(1);
        stat_rd_i = 1'b0; ctrl1_wr_i = 1'b0;
        check("R12 same cycle", modf_o, 1);
        // proper sequence
        stat_rd_i = 1'b1; tick(1); stat_rd_i = 1'b0;
        check("R12 read only", modf_o, 1);
        tick(2);
        ctrl1_wr_i = 1'b1; tick(1); ctrl1_wr_i = 1'b0;
        check("R12 cleared", modf_o, 0);
        check("R12 master back", pads(), exp_pads(1, 1, 0, 0, 0, 1, 0));

        // R10: fault in single-wire master with output enable, not busy
        set_mode(1, 1, 1, 1, 0, 1);
        tick(1);
        check("R3 before fault", pads(), exp_pads(1, 1, 1, 1, 0, 1, 0));
        ss_n_i = 1'b0; tick(3);
        check("R10 modf", modf_o, 1);
        check("R10 clr_oe", clr_bidir_oe_o, 1);
        check("R10 clr_mstr", clr_mstr_o, 1);
        check("R9 idle no abort", abort_o, 0);
        check("R5 sin as slave", sin_sel_o, 1);
        check("R9 pads off bidir", pads(), exp_pads(1, 1, 1, 1, 0, 1, 1));
        clear_flag();
        check("R12 cleared bidir", modf_o, 0);

        // R10: single-wire with output enable off, no clear pulse
        set_mode(1, 1, 1, 0, 0, 1);
        ss_n_i = 1'b0; tick(3);
        check("R10 oe off modf", modf_o, 1);
        check("R10 oe off no pulse", clr_bidir_oe_o, 0);
        clear_flag();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule